// File: doc/BRIEF.md
# Per-Context Register Scoreboard with Class-Timed Release

This block tracks which architectural registers hold results that are not yet available, for a core that runs several hardware thread contexts with their own register sets. Each context keeps one busy flag per register, and no renaming is done. When an instruction issues, its destination register is marked busy, and a countdown is loaded from the latency of the instruction's class. The flag drops by itself when the countdown runs out.

A load that misses the first-level cache is marked busy with no countdown. Its flag stays set until a writeback clear names that register. A combinational check port takes a context and two source registers and reports whether both are free, so a candidate instruction can issue in that cycle. The highest-numbered register of every context reads as constant zero and is never busy.

Top module: `ctx_reg_scoreboard`

## Requirements
- R1: After reset, every register of every context reads as ready.
- R2: An issue of a timed class makes its destination busy for exactly L cycles after the issue cycle. The class codes on `iss_cls` and their latencies L are: 1 integer=1, 2 conditional move=2, 3 short multiply=8, 4 long multiply=16, 5 FP=4, 6 short FP divide=17, 7 long FP divide=30, 8 load hit=2.
- R3: Class code 0 (compare) and the unused codes 10 to 15 never make the destination busy. A dependent instruction sees the register ready in the very next cycle.
- R4: Class code 9 (load miss) makes the destination busy with no time limit.
- R5: A writeback clear on a busy register makes it ready in the next cycle.
- R6: Register NREG-1 of every context is always ready, whatever is issued to it.
- R7: Busy state is private to each context. An issue in one context leaves the same register number in other contexts unchanged.
- R8: An issue that lands on a register in the same cycle its countdown expires takes effect. The register stays busy and the countdown restarts.
- R9: `chk_ready` is high only when both source registers are ready.
- R10: An issue and a writeback clear that name the same register in the same cycle resolve in favour of the issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Issue strobe |
| iss_ctx | input | CTXW | Context of the issuing instruction |
| iss_rd | input | RW | Destination register |
| iss_cls | input | 4 | Instruction class code |
| wb_vld | input | 1 | Writeback clear strobe |
| wb_ctx | input | CTXW | Context of the writeback |
| wb_rd | input | RW | Register to release |
| chk_ctx | input | CTXW | Context of the candidate instruction |
| chk_rs1 | input | RW | First source register |
| chk_rs2 | input | RW | Second source register |
| chk_ready | output | 1 | Both sources ready |

## Verification
A countdown loaded with the wrong value, or decremented incorrectly, changes how many cycles the check port reports a register as busy. That error appears within one latency window of the issue, so the bench measures the exact busy span for every class in every context. A flag that is set in the wrong place appears at once. It either holds up an unrelated register or context, or leaves a dependent instruction free in the cycle right after its producer. A missed-load flag that leaks away shows up only after a long wait, so the bench holds one for many cycles before it releases it.

// File: rtl/ctx_reg_scoreboard.sv
module ctx_reg_scoreboard #(
  parameter int NCTX       = 4,
  parameter int NREG       = 32,
  parameter int CW         = 5,
  parameter int LAT_INT    = 1,
  parameter int LAT_CMOV   = 2,
  parameter int LAT_MUL_S  = 8,
  parameter int LAT_MUL_L  = 16,
  parameter int LAT_FP     = 4,
  parameter int LAT_FDIV_S = 17,
  parameter int LAT_FDIV_L = 30,
  parameter int LAT_LDHIT  = 2,
  localparam int CTXW = $clog2(NCTX),
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_vld,
  input  logic [CTXW-1:0] iss_ctx,
  input  logic [RW-1:0]   iss_rd,
  input  logic [3:0]      iss_cls,
  input  logic            wb_vld,
  input  logic [CTXW-1:0] wb_ctx,
  input  logic [RW-1:0]   wb_rd,
  input  logic [CTXW-1:0] chk_ctx,
  input  logic [RW-1:0]   chk_rs1,
  input  logic [RW-1:0]   chk_rs2,
  output logic            chk_ready
);
  localparam int IW = CTXW + RW;
  localparam int NENT = NCTX * NREG;
  localparam logic [3:0] CL_LDMISS = 4'd9;

  function automatic logic [CW-1:0] lat_of(input logic [3:0] c);
    case (c)
      4'd1:    lat_of = CW'(LAT_INT);
      4'd2:    lat_of = CW'(LAT_CMOV);
      4'd3:    lat_of = CW'(LAT_MUL_S);
      4'd4:    lat_of = CW'(LAT_MUL_L);
      4'd5:    lat_of = CW'(LAT_FP);
      4'd6:    lat_of = CW'(LAT_FDIV_S);
      4'd7:    lat_of = CW'(LAT_FDIV_L);
      4'd8:    lat_of = CW'(LAT_LDHIT);
      default: lat_of = '0;
    endcase
  endfunction

  logic [IW-1:0]   iss_idx, wb_idx;
  logic [CW-1:0]   iss_lat;
  logic            iss_miss, iss_sets;
  logic [NENT-1:0] pend;

  assign iss_idx  = {iss_ctx, iss_rd};
  assign wb_idx   = {wb_ctx, wb_rd};
  assign iss_lat  = lat_of(iss_cls);
  assign iss_miss = (iss_cls == CL_LDMISS);
  assign iss_sets = iss_miss || (iss_lat != '0);

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    if ((i % NREG) == NREG - 1) begin : g_zero
      assign pend[i] = 1'b0;
    end else begin : g_reg
      logic          timed_q;
      logic [CW-1:0] cnt_q;
      logic          hit_iss, hit_wb;
      assign hit_iss = iss_vld && (iss_idx == IW'(i));
      assign hit_wb  = wb_vld && (wb_idx == IW'(i));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend[i] <= 1'b0;
          timed_q <= 1'b0;
          cnt_q   <= '0;
        end else if (hit_iss) begin
          pend[i] <= iss_sets;
          timed_q <= !iss_miss;
          cnt_q   <= iss_lat;
        end else if (hit_wb) begin
          pend[i] <= 1'b0;
        end else if (pend[i] && timed_q) begin
          if (cnt_q == CW'(1)) pend[i] <= 1'b0;
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign chk_ready = !pend[{chk_ctx, chk_rs1}] && !pend[{chk_ctx, chk_rs2}];
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NCTX = 4,
  parameter int NREG = 32,
  localparam int CTXW = $clog2(NCTX),
  localparam int RW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_vld,
  input logic [CTXW-1:0] iss_ctx,
  input logic [RW-1:0]   iss_rd,
  input logic [3:0]      iss_cls,
  input logic            wb_vld,
  input logic [CTXW-1:0] wb_ctx,
  input logic [RW-1:0]   wb_rd,
  input logic [CTXW-1:0] chk_ctx,
  input logic [RW-1:0]   chk_rs1,
  input logic [RW-1:0]   chk_rs2,
  input logic            chk_ready
);
  localparam logic [RW-1:0] ZR = RW'(NREG - 1);
  logic busy_cls, free_cls;
  assign busy_cls = (iss_cls >= 4'd1) && (iss_cls <= 4'd9);
  assign free_cls = !busy_cls;

  assert_ready_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> chk_ready);

  // R2 and R8: any busy-class issue wins and is visible next cycle
  assert_busy_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && busy_cls && iss_rd != ZR) |=>
      (!(chk_ctx == $past(iss_ctx) && chk_rs1 == $past(iss_rd)) || !chk_ready));

  assert_free_class_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && free_cls) |=>
      (!(chk_ctx == $past(iss_ctx) && chk_rs1 == $past(iss_rd) && chk_rs2 == ZR) || chk_ready));

  assert_wb_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && !(iss_vld && iss_ctx == wb_ctx && iss_rd == wb_rd)) |=>
      (!(chk_ctx == $past(wb_ctx) && chk_rs1 == $past(wb_rd) && chk_rs2 == ZR) || chk_ready));

  assert_zero_reg_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_rs1 == ZR && chk_rs2 == ZR) |-> chk_ready);
endmodule

bind ctx_reg_scoreboard sb_checker #(.NCTX(NCTX), .NREG(NREG)) chk_i (.*);

// File: tb/ctx_reg_scoreboard_tb.sv
module ctx_reg_scoreboard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCTX = 4;
  localparam int NREG = 32;
  localparam logic [4:0] ZR = 5'd31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_vld = 1'b0, wb_vld = 1'b0;
  logic [1:0] iss_ctx = '0, wb_ctx = '0, chk_ctx = '0;
  logic [4:0] iss_rd = '0, wb_rd = '0, chk_rs1 = '0, chk_rs2 = '0;
  logic [3:0] iss_cls = '0;
  logic chk_ready;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_reg_scoreboard #(.NCTX(NCTX), .NREG(NREG)) dut_i (.*);

  function automatic int exp_lat(input int c);
    case (c)
      1: return 1;  2: return 2;  3: return 8;  4: return 16;
      5: return 4;  6: return 17; 7: return 30; 8: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe(input int c, input int a, input int b);
    chk_ctx = 2'(c); chk_rs1 = 5'(a); chk_rs2 = 5'(b);
    #1;
  endtask

  task automatic issue(input int c, input int rd, input int cls);
    @(negedge clk);
    iss_vld = 1'b1; iss_ctx = 2'(c); iss_rd = 5'(rd); iss_cls = 4'(cls);
    chk_ctx = 2'(c); chk_rs1 = 5'(rd); chk_rs2 = ZR;
    @(negedge clk);
    iss_vld = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    #1;
    while (!chk_ready && n < 45) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    for (int c = 0; c < NCTX; c++) begin
      int bad = 0;
      for (int r = 0; r < NREG; r++) begin
        probe(c, r, r);
        if (!chk_ready) bad++;
      end
      check(bad == 0, "R1 reset ready", bad, 0);
    end
    // R2 / R3 sweep over classes and contexts
    for (int c = 0; c < NCTX; c++)
      for (int cls = 0; cls < 16; cls++) begin
        if (cls == 9) continue;
        issue(c, (cls + 3 * c) % 31, cls);
        count_busy(n);
        check(n == exp_lat(cls), (exp_lat(cls) == 0) ? "R3 zero latency" : "R2 busy span",
              n, exp_lat(cls));
      end
    // R4 / R5 load miss
    issue(2, 7, 9);
    repeat (60) @(negedge clk);
    probe(2, 7, ZR);
    check(!chk_ready, "R4 miss still busy", chk_ready, 0);
    wb_vld = 1'b1; wb_ctx = 2'd2; wb_rd = 5'd7;
    @(negedge clk);
    wb_vld = 1'b0;
    probe(2, 7, ZR);
    check(chk_ready, "R5 writeback release", chk_ready, 1);
    // R6
    issue(1, 31, 7);
    probe(1, 31, 31);
    check(chk_ready, "R6 zero register", chk_ready, 1);
    // R7
    issue(0, 9, 7);
    for (int c = 1; c < NCTX; c++) begin
      probe(c, 9, ZR);
      check(chk_ready, "R7 other context", chk_ready, 1);
    end
    probe(0, 9, ZR);
    check(!chk_ready, "R7 own context", chk_ready, 0);
    repeat (32) @(negedge clk);
    // R8 issue on expiry cycle
    issue(3, 12, 2);
    @(negedge clk);
    probe(3, 12, ZR);
    check(!chk_ready, "R8 busy before expiry", chk_ready, 0);
    iss_vld = 1'b1; iss_ctx = 2'd3; iss_rd = 5'd12; iss_cls = 4'd5;
    @(negedge clk);
    iss_vld = 1'b0;
    count_busy(n);
    check(n == 4, "R8 restarted span", n, 4);
    // R10 issue and writeback together
    issue(2, 14, 9);
    @(negedge clk);
    iss_vld = 1'b1; iss_ctx = 2'd2; iss_rd = 5'd14; iss_cls = 4'd5;
    wb_vld = 1'b1; wb_ctx = 2'd2; wb_rd = 5'd14;
    @(negedge clk);
    iss_vld = 1'b0; wb_vld = 1'b0;
    probe(2, 14, ZR);
    count_busy(n);
    check(n == 4, "R10 issue beats writeback", n, 4);
    // R9
    issue(3, 4, 4);
    issue(3, 5, 4);
    probe(3, 4, 0);
    check(!chk_ready, "R9 rs1 busy", chk_ready, 0);
    probe(3, 0, 5);
    check(!chk_ready, "R9 rs2 busy", chk_ready, 0);
    probe(3, 0, 1);
    check(chk_ready, "R9 both free", chk_ready, 1);
    repeat (20) @(negedge clk);
    probe(3, 4, 5);
    check(chk_ready, "R9 after release", chk_ready, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule